// File: doc/BRIEF.md
# Synchronous Burst SRAM Command Engine

This block models a clocked burst SRAM whose 36-bit word is split into four 9-bit lanes, backed by a small internal array. On every rising clock edge it decodes a command from three chip-select pins, a load/continue pin, a direction pin, four lane-write strobes, an output-enable pin, a stall pin and a sleep pin. A load edge either deselects the device or starts a read or write burst at the external address. A continue edge carries on the current burst from an internal 2-bit wrapping counter.

The model is pipelined. Read data is registered out on the second edge after the command edge that names it. Write data is taken from `wdata` on that same second edge. The bus is a plain output word `rdata` plus a drive flag `rdata_drive`; when the flag is low the bus is high-impedance. A stalled edge freezes the whole engine. Sleep forces the bus off at once and discards everything in flight.

The data pins carry no valid/ready handshake. A memory device cannot push back on its host: stall and sleep are its only flow controls, and the host owns both.

Top module: `sb_burst_sram`

## Requirements
- R1: On a load edge (`step`=0) where `sel_a_n`=1, `sel_b`=0 or `sel_c_n`=1, the device is deselected. `rdata_drive` is low for that slot, two edges later.
- R2: A load edge with `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 starts a burst at `addr`. `wr_n`=0 makes it a write burst and `wr_n`=1 a read burst. Read data and `rdata_drive`=1 appear after the second following unstalled edge.
- R3: A continue edge (`step`=1) inside a burst keeps the burst's direction and ignores `wr_n`. It uses the previous burst address with bits [1:0] incremented modulo 4 and the upper bits unchanged.
- R4: A continue edge with no burst open (after reset, a deselect or sleep) does nothing and leaves the bus high-impedance.
- R5: A read slot whose `oe_n` was 1 on its command edge is a dummy read. `rdata_drive` stays low for that slot.
- R6: A write slot with `lane_wr_n`=4'b1111 modifies no array location.
- R7: Each lane-write strobe gates one lane: `lane_wr_n[i]`=0 writes `wdata[9*i+8:9*i]`, and lanes whose strobe is 1 keep their old contents.
- R8: A write slot never drives the bus, whatever the value of `oe_n`.
- R9: An edge with `stall`=1 is ignored. No write happens, the pipeline and the burst counter hold, and `rdata` and `rdata_drive` keep their values.
- R10: While `sleep`=1, `rdata_drive` is low, without waiting for an edge. A sleep edge discards all in-flight slots, so pending writes are not performed, and it closes any open burst.
- R11: After reset `rdata_drive` is low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Sleep; overrides all other inputs |
| stall | input | 1 | Ignore this edge when high |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| step | input | 1 | 0 = load new address, 1 = continue burst |
| wr_n | input | 1 | Burst direction on load: 0 write, 1 read |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable for read slots, active low |
| addr | input | 6 | External word address |
| wdata | input | 36 | Write data, taken two edges after its command |
| rdata | output | 36 | Read data word |
| rdata_drive | output | 1 | High when the bus is driven, low when high-impedance |

## Verification
A corrupt burst counter shows up as a wrong word on `rdata`, two edges after the first bad continue. A stale burst-open flag makes `rdata_drive` rise where a continue should have been idle, with the same two-edge lag. A stall that leaks through the pipeline changes `rdata` on the very edge it should hold. A write that lands in the wrong place, lands on a stalled edge, or touches a masked lane only becomes visible when that word is read back, at least five edges later.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    SB_IDLE  = 2'd0,
    SB_READ  = 2'd1,
    SB_WRITE = 2'd2
  } sb_op_e;
endpackage

// File: rtl/sb_cmd_decode.sv
module sb_cmd_decode
  import sb_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 4,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              stall,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              step,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output sb_op_e            cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_lanes,
  output logic              cmd_show
);
  logic              chip_on;
  logic              burst_live;
  logic              burst_wr;
  logic [ADDR_W-1:0] burst_addr;
  logic [ADDR_W-1:0] bumped;
  logic [BURST_BITS-1:0] low_next;

  assign chip_on  = ~sel_a_n & sel_b & ~sel_c_n;
  assign low_next = burst_addr[BURST_BITS-1:0] + BURST_BITS'(1);
  assign bumped   = {burst_addr[ADDR_W-1:BURST_BITS], low_next};

  always_comb begin
    cmd_op    = SB_IDLE;
    cmd_addr  = addr;
    cmd_lanes = ~lane_wr_n;
    cmd_show  = ~oe_n;
    if (!step) begin
      if (chip_on) cmd_op = wr_n ? SB_READ : SB_WRITE;
    end else if (burst_live) begin
      cmd_op   = burst_wr ? SB_WRITE : SB_READ;
      cmd_addr = bumped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_live <= 1'b0;
      burst_wr   <= 1'b0;
      burst_addr <= '0;
    end else if (sleep) begin
      burst_live <= 1'b0;
    end else if (!stall) begin
      if (!step) begin
        burst_live <= chip_on;
        burst_wr   <= ~wr_n;
        burst_addr <= addr;
      end else if (burst_live) begin
        burst_addr <= bumped;
      end
    end
  end
endmodule

// File: rtl/sb_pipe.sv
module sb_pipe
  import sb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              stall,
  input  sb_op_e            in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_lanes,
  input  logic              in_show,
  output sb_op_e            out_op,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LANES-1:0]  out_lanes,
  output logic              out_show
);
  localparam int SW = 2 + ADDR_W + LANES + 1;

  logic [SW-1:0] stg [DEPTH];
  logic [SW-1:0] head;
  logic [SW-1:0] tail;

  assign head = {in_op, in_addr, in_lanes, in_show};
  assign tail = stg[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else if (sleep) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else if (!stall) begin
      for (int i = DEPTH - 1; i > 0; i--) stg[i] <= stg[i-1];
      stg[0] <= head;
    end
  end

  assign out_op    = sb_op_e'(tail[SW-1 -: 2]);
  assign out_addr  = tail[ADDR_W+LANES : LANES+1];
  assign out_lanes = tail[LANES:1];
  assign out_show  = tail[0];
endmodule

// File: rtl/sb_lane_array.sv
module sb_lane_array
  import sb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    stall,
  input  sb_op_e                  op,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lanes,
  input  logic                    show,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    drive
);
  localparam int WORDS = 1 << ADDR_W;

  logic go;
  logic do_rd;
  logic do_wr;

  assign go    = ~stall & ~sleep;
  assign do_rd = go & (op == SB_READ) & show;
  assign do_wr = go & (op == SB_WRITE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [WORDS];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (do_wr && lanes[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (do_rd) rd_q <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      drive <= 1'b0;
    else if (sleep)  drive <= 1'b0;
    else if (!stall) drive <= (op == SB_READ) & show;
  end
endmodule

// File: rtl/sb_burst_sram.sv
module sb_burst_sram
  import sb_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 4,
  parameter int LANE_W     = 9,
  parameter int BURST_BITS = 2,
  parameter int LATENCY    = 2,
  localparam int DATA_W    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              stall,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              step,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drive
);
  sb_op_e            c_op, p_op;
  logic [ADDR_W-1:0] c_addr, p_addr;
  logic [LANES-1:0]  c_lanes, p_lanes;
  logic              c_show, p_show;
  logic              drive_q;

  sb_cmd_decode #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BURST_BITS(BURST_BITS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .stall(stall),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .step(step), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
    .addr(addr),
    .cmd_op(c_op), .cmd_addr(c_addr), .cmd_lanes(c_lanes), .cmd_show(c_show)
  );

  sb_pipe #(
    .ADDR_W(ADDR_W), .LANES(LANES), .DEPTH(LATENCY)
  ) u_pipe (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .stall(stall),
    .in_op(c_op), .in_addr(c_addr), .in_lanes(c_lanes), .in_show(c_show),
    .out_op(p_op), .out_addr(p_addr), .out_lanes(p_lanes), .out_show(p_show)
  );

  sb_lane_array #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_arr (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .stall(stall),
    .op(p_op), .addr(p_addr), .lanes(p_lanes), .show(p_show),
    .wdata(wdata), .rdata(rdata), .drive(drive_q)
  );

  assign rdata_drive = drive_q & ~sleep;
endmodule

// File: rtl/sb_burst_sram_chk.sv
module sb_burst_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              stall,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              step,
  input logic              wr_n,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_drive
);
  logic go, ld_off, ld_wr;

  assign go     = ~stall & ~sleep;
  assign ld_off = ~step & (sel_a_n | ~sel_b | sel_c_n);
  assign ld_wr  = ~step & ~sel_a_n & sel_b & ~sel_c_n & ~wr_n;

  // R10: a sleep edge leaves the bus released
  p_sleep_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sleep)) |-> !rdata_drive);

  // R9: a stalled edge keeps the drive state
  p_stall_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stall) && !$past(sleep) && !sleep) |-> $stable(rdata_drive));

  // R9: a stalled edge keeps the data word
  p_stall_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stall) && !$past(sleep)) |-> $stable(rdata));

  // R1: a deselecting load produces an undriven slot
  p_deselect_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && $past(ld_off, 3) && $past(go, 3) && $past(go, 2) && $past(go, 1))
    |-> !rdata_drive);

  // R8: a write burst start never drives the bus
  p_write_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && $past(ld_wr, 3) && $past(go, 3) && $past(go, 2) && $past(go, 1))
    |-> !rdata_drive);
endmodule

bind sb_burst_sram sb_burst_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .stall(stall),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
  .step(step), .wr_n(wr_n), .rdata(rdata), .rdata_drive(rdata_drive)
);

// File: tb/sb_burst_sram_test.sv
module sb_burst_sram_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep = 1'b0, stall = 1'b0;
  logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic        step = 1'b0, wr_n = 1'b1, oe_n = 1'b0;
  logic [3:0]  lane_wr_n = 4'hF;
  logic [5:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rdata_drive;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  sb_burst_sram uut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .stall(stall),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .step(step), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_load(logic w_n, logic [5:0] a, logic [3:0] ln, logic oen);
    step = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    wr_n = w_n; addr = a; lane_wr_n = ln; oe_n = oen;
  endtask

  task automatic set_cont(logic w_n, logic [3:0] ln, logic oen);
    step = 1; wr_n = w_n; lane_wr_n = ln; oe_n = oen; addr = 6'h3F;
  endtask

  task automatic set_desel();
    step = 0; sel_a_n = 1; sel_b = 1; sel_c_n = 0; wr_n = 0; oe_n = 0;
  endtask

  task automatic wr_word(logic [5:0] a, logic [3:0] ln, logic [35:0] d);
    set_load(0, a, ln, 0); tick();
    set_desel(); tick();
    wdata = d; tick();
    wdata = '0;
  endtask

  task automatic rd_word(logic [5:0] a, output logic [35:0] d, output logic drv);
    set_load(1, a, 4'hF, 0); tick();
    set_desel(); tick(); tick();
    d = rdata; drv = rdata_drive;
  endtask

  task automatic t_reset();
    chk("R11 drive after reset", {35'd0, rdata_drive}, 36'd0);
    set_cont(1, 4'hF, 0); tick(); tick(); tick();
    chk("R4 continue after reset", {35'd0, rdata_drive}, 36'd0);
    set_desel(); tick();
  endtask

  task automatic t_single();
    logic [35:0] d; logic v;
    wr_word(6'h05, 4'h0, 36'h123456789);
    wr_word(6'h06, 4'h0, 36'hFEDCBA987);
    rd_word(6'h05, d, v);
    chk("R2 read data a05", d, 36'h123456789);
    chk("R2 read drive", {35'd0, v}, 36'd1);
    rd_word(6'h06, d, v);
    chk("R2 read data a06", d, 36'hFEDCBA987);
  endtask

  task automatic t_burst();
    logic [35:0] d; logic v;
    logic [35:0] w [4] = '{36'h111111111, 36'h222222222, 36'h333333333, 36'h444444444};
    // write burst from 0x0E: visits 0E, 0F, 0C, 0D
    set_load(0, 6'h0E, 4'h0, 0); tick();
    set_cont(1, 4'h0, 0); tick();
    set_cont(1, 4'h0, 0); wdata = w[0]; tick();
    chk("R8 write slot undriven", {35'd0, rdata_drive}, 36'd0);
    set_cont(1, 4'h0, 0); wdata = w[1]; tick();
    set_desel(); wdata = w[2]; tick();
    wdata = w[3]; tick();
    wdata = '0;
    rd_word(6'h0C, d, v); chk("R3 wrap to 0C", d, w[2]);
    rd_word(6'h0D, d, v); chk("R3 wrap to 0D", d, w[3]);
    rd_word(6'h0F, d, v); chk("R3 step to 0F", d, w[1]);
    // read burst from 0x0D with wr_n low on continues
    set_load(1, 6'h0D, 4'hF, 0); tick();
    set_cont(0, 4'h0, 0); tick();
    set_cont(0, 4'h0, 0); tick();
    chk("R3 read burst beat0", rdata, w[3]);
    set_cont(0, 4'h0, 0); tick();
    chk("R3 read burst beat1", rdata, w[0]);
    set_desel(); tick();
    chk("R3 read burst beat2", rdata, w[1]);
    tick();
    chk("R3 read burst beat3", rdata, w[2]);
    chk("R3 read burst drive", {35'd0, rdata_drive}, 36'd1);
    tick();
    chk("R1 idle after burst", {35'd0, rdata_drive}, 36'd0);
  endtask

  task automatic t_dummy();
    set_load(1, 6'h05, 4'hF, 1); tick();
    set_desel(); tick(); tick();
    chk("R5 dummy read undriven", {35'd0, rdata_drive}, 36'd0);
  endtask

  task automatic t_abort();
    logic [35:0] d; logic v;
    wr_word(6'h20, 4'h0, 36'hA0A0A0A0A);
    wr_word(6'h20, 4'hF, 36'h5F5F5F5F5);
    rd_word(6'h20, d, v);
    chk("R6 abort keeps word", d, 36'hA0A0A0A0A);
  endtask

  task automatic t_lanes();
    logic [35:0] d; logic v;
    logic [35:0] m = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
    wr_word(6'h21, 4'h0, 36'hA5A5A5A5A);
    wr_word(6'h21, 4'b1010, 36'h5C3C3C3C3);
    rd_word(6'h21, d, v);
    chk("R7 lanes 0,2 merged", d, (36'hA5A5A5A5A & ~m) | (36'h5C3C3C3C3 & m));
  endtask

  task automatic t_desel();
    for (int k = 0; k < 3; k++) begin
      set_load(1, 6'h05, 4'hF, 0);
      if (k == 0) sel_a_n = 1;
      if (k == 1) sel_b = 0;
      if (k == 2) sel_c_n = 1;
      tick();
      set_desel(); tick(); tick();
      chk($sformatf("R1 deselect pin %0d", k), {35'd0, rdata_drive}, 36'd0);
    end
    set_cont(1, 4'hF, 0); tick(); tick(); tick();
    chk("R4 continue after deselect", {35'd0, rdata_drive}, 36'd0);
    set_desel(); tick();
  endtask

  task automatic t_stall();
    logic [35:0] d; logic v;
    set_load(1, 6'h0C, 4'hF, 0); tick();
    set_cont(1, 4'hF, 0); tick();
    tick();
    chk("R9 pre-stall beat", rdata, 36'h333333333);
    stall = 1; tick(); tick();
    chk("R9 stall holds data", rdata, 36'h333333333);
    chk("R9 stall holds drive", {35'd0, rdata_drive}, 36'd1);
    stall = 0; tick();
    chk("R9 counter frozen beat1", rdata, 36'h444444444);
    set_desel(); tick();
    chk("R9 counter frozen beat2", rdata, 36'h111111111);
    tick();
    chk("R9 counter frozen beat3", rdata, 36'h222222222);
    // stalled write edge must not store its data
    set_load(0, 6'h22, 4'h0, 0); tick();
    set_desel(); tick();
    stall = 1; wdata = 36'hBADBADBAD; tick();
    chk("R9 write stall undriven", {35'd0, rdata_drive}, 36'd0);
    stall = 0; wdata = 36'h0C0FFEE00; tick();
    wdata = '0;
    rd_word(6'h22, d, v);
    chk("R9 stalled edge no write", d, 36'h0C0FFEE00);
  endtask

  task automatic t_sleep();
    logic [35:0] d; logic v;
    set_load(1, 6'h0C, 4'hF, 0); tick();
    set_cont(1, 4'hF, 0); tick();
    tick();
    chk("R10 driving before sleep", {35'd0, rdata_drive}, 36'd1);
    sleep = 1; #1;
    chk("R10 sleep releases at once", {35'd0, rdata_drive}, 36'd0);
    tick();
    sleep = 0; tick(); tick(); tick();
    chk("R10 burst closed by sleep", {35'd0, rdata_drive}, 36'd0);
    set_desel(); tick();
    set_load(0, 6'h20, 4'h0, 0); tick();
    set_desel(); tick();
    sleep = 1; wdata = 36'h999999999; tick();
    sleep = 0; wdata = '0; tick();
    rd_word(6'h20, d, v);
    chk("R10 sleep drops pending write", d, 36'hA0A0A0A0A);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_burst();
    t_dummy();
    t_abort();
    t_lanes();
    t_desel();
    t_stall();
    t_sleep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule